// File: doc/BRIEF.md
# Serial Status Flag Register

This block is the 8-bit status register of a serial communication controller. The serial datapath raises events such as transmit buffer empty, receive buffer full and receive errors. The block stores each event as a sticky flag that a CPU can read and clear over a single-cycle register port.

Software can clear a sticky flag only by writing 0 to its bit. The clear takes effect only if an earlier read saw that flag at 1. Each sticky flag therefore keeps its own arm bit. A read that returns the flag as 1 sets the arm bit, and the next write to the register consumes it.

The register also carries three other bits:
- a transmit-end bit that follows the datapath,
- a received multiprocessor bit that is loaded at the end of each received frame,
- a multiprocessor transmit bit that software can read and write, and that is sent with the next frame.

A reset, or a standby request, puts the register back to its initial state.

Top module: `ser_flag_reg`

## Requirements
- R1: After reset, and in the cycle after any clock edge with `standby_i` high, the register reads 0x84 and every arm bit is clear. Standby takes priority over all other inputs.
- R2: A read sets the arm bit of each sticky flag that the read returns as 1. A later write with that bit at 0 clears the flag. Sticky bit positions: bit 7 transmit empty, bit 6 receive full, bit 5 overrun, bit 4 framing error, bit 3 parity error.
- R3: A write of 0 to a sticky flag whose arm bit is clear leaves the flag unchanged.
- R4: A write of 1 never changes a sticky flag. Any write clears every arm bit, so a second write of 0 without a new read does not clear the flag.
- R5: A pulse on `txe_set_i`, `rxf_set_i`, `ovr_set_i`, `frm_set_i` or `par_set_i` sets bit 7, 6, 5, 4 or 3 respectively at the next clock edge.
- R6: When a hardware set and an armed write-0 clear hit the same flag in the same cycle, the flag stays 1.
- R7: Bit 2 (transmit end) takes the value of `tx_end_i` at each clock edge and ignores CPU writes.
- R8: Bit 1 (received multiprocessor bit) loads `rx_mpb_i` on each edge where `rx_done_i` is high, otherwise holds, and ignores CPU writes.
- R9: Bit 0 is loaded from `wdata_i[0]` on every write, and `mpb_tx_o` shows its value.
- R10: `rdata_o` shows the current register contents when `cs_i` is high and `we_i` is low, and 0 otherwise. A read has no effect other than arming.
- R11: Standby clears all arm bits, so a write of 0 after standby does not clear a flag until a new read has seen it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| standby_i | input | 1 | Synchronous standby request; reinitializes the register |
| cs_i | input | 1 | Register access select |
| we_i | input | 1 | 1 = write, 0 = read (when selected) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| txe_set_i | input | 1 | Transmit data moved to shift register |
| rxf_set_i | input | 1 | Received byte stored in receive buffer |
| ovr_set_i | input | 1 | Receive overrun detected |
| frm_set_i | input | 1 | Receive framing error detected |
| par_set_i | input | 1 | Receive parity error detected |
| tx_end_i | input | 1 | Transmit-end level from datapath |
| rx_done_i | input | 1 | Receive-complete strobe |
| rx_mpb_i | input | 1 | Multiprocessor bit of the received frame |
| mpb_tx_o | output | 1 | Multiprocessor bit for the next transmitted frame |

## Verification
The hardest case to reach from the ports is a write that would clear a flag if its arm bit were set, but where the arm bit was dropped by an intervening write or a standby. In that case the flag must survive. A second hard case is a hardware set that lands in the same cycle as an armed clear. Directed sequences build each of these cases in turn: read, write 1, then write 0; read, standby, set, then write 0; read, then write 0 together with a set pulse. A seeded random phase then uses sparse set pulses and frequent reads and writes, so that arm, consume and clear chains occur many times and every read is compared with a bench model.

// File: rtl/ser_flag_pkg.sv
package ser_flag_pkg;
  localparam int REG_W      = 8;
  localparam int NUM_STICKY = 5;
  localparam int STICKY_LSB = 3;
  localparam int TEND_BIT   = 2;
  localparam int MPB_BIT    = 1;
  localparam int MPBT_BIT   = 0;
  // Reset value of sticky flags: only transmit-empty (top flag) starts at 1
  localparam logic [NUM_STICKY-1:0] STICKY_RST = 5'b10000;
  localparam logic [REG_W-1:0]      REG_RST    = 8'h84;
endpackage

// File: rtl/ser_flag_cell.sv
// One sticky flag with its read-arm qualifier.
module ser_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q & flag_q;
    if (standby_i) begin
      flag_d = RST_VAL;
      arm_d  = 1'b0;
    end else begin
      if (set_i)
        flag_d = 1'b1;
      else if (wr_i && arm_q && !wbit_i)
        flag_d = 1'b0;
      if (wr_i)
        arm_d = 1'b0;
      else if (rd_i && flag_q)
        arm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ser_flag_aux.sv
// Transmit-end, received multiprocessor bit and multiprocessor transmit bit.
module ser_flag_aux (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic tx_end_i,
  input  logic rx_done_i,
  input  logic rx_mpb_i,
  output logic tend_o,
  output logic mpb_o,
  output logic mpbt_o
);
  logic tend_q, tend_d;
  logic mpb_q, mpb_d;
  logic mpbt_q, mpbt_d;

  always_comb begin
    tend_d = tx_end_i;
    mpb_d  = mpb_q;
    mpbt_d = mpbt_q;
    if (standby_i) begin
      tend_d = 1'b1;
      mpb_d  = 1'b0;
      mpbt_d = 1'b0;
    end else begin
      if (rx_done_i) mpb_d  = rx_mpb_i;
      if (wr_i)      mpbt_d = wbit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
      mpb_q  <= 1'b0;
      mpbt_q <= 1'b0;
    end else begin
      tend_q <= tend_d;
      mpb_q  <= mpb_d;
      mpbt_q <= mpbt_d;
    end
  end

  assign tend_o = tend_q;
  assign mpb_o  = mpb_q;
  assign mpbt_o = mpbt_q;
endmodule

// File: rtl/ser_flag_reg.sv
module ser_flag_reg
  import ser_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby_i,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             txe_set_i,
  input  logic             rxf_set_i,
  input  logic             ovr_set_i,
  input  logic             frm_set_i,
  input  logic             par_set_i,
  input  logic             tx_end_i,
  input  logic             rx_done_i,
  input  logic             rx_mpb_i,
  output logic             mpb_tx_o
);
  logic                  rd_stb, wr_stb;
  logic [NUM_STICKY-1:0] set_vec;
  logic [NUM_STICKY-1:0] sticky_q;
  logic                  tend_q, mpb_q, mpbt_q;
  logic [REG_W-1:0]      status_q;

  assign rd_stb  = cs_i & ~we_i;
  assign wr_stb  = cs_i & we_i;
  assign set_vec = {txe_set_i, rxf_set_i, ovr_set_i, frm_set_i, par_set_i};

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    ser_flag_cell #(.RST_VAL(STICKY_RST[i])) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby_i (standby_i),
      .set_i     (set_vec[i]),
      .rd_i      (rd_stb),
      .wr_i      (wr_stb),
      .wbit_i    (wdata_i[STICKY_LSB+i]),
      .flag_o    (sticky_q[i])
    );
  end

  ser_flag_aux u_aux (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .wr_i      (wr_stb),
    .wbit_i    (wdata_i[MPBT_BIT]),
    .tx_end_i  (tx_end_i),
    .rx_done_i (rx_done_i),
    .rx_mpb_i  (rx_mpb_i),
    .tend_o    (tend_q),
    .mpb_o     (mpb_q),
    .mpbt_o    (mpbt_q)
  );

  always_comb begin
    status_q = '0;
    status_q[STICKY_LSB +: NUM_STICKY] = sticky_q;
    status_q[TEND_BIT] = tend_q;
    status_q[MPB_BIT]  = mpb_q;
    status_q[MPBT_BIT] = mpbt_q;
  end

  assign rdata_o  = rd_stb ? status_q : '0;
  assign mpb_tx_o = mpbt_q;
endmodule

// File: rtl/ser_flag_reg_chk.sv
module ser_flag_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       standby_i,
  input logic       cs_i,
  input logic       we_i,
  input logic       txe_set_i,
  input logic       rxf_set_i,
  input logic       ovr_set_i,
  input logic       frm_set_i,
  input logic       par_set_i,
  input logic       tx_end_i,
  input logic       rx_done_i,
  input logic       mpb_tx_o,
  input logic [7:0] rdata_o,
  input logic [7:0] status_q
);
  logic [4:0] sets;
  assign sets = {txe_set_i, rxf_set_i, ovr_set_i, frm_set_i, par_set_i};

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> status_q == 8'h84);

  p_hw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_i && (|sets)) |=> ((status_q[7:3] & $past(sets)) == $past(sets)));

  p_no_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_i && sets == 5'b0) |=> ((status_q[7:3] & ~$past(status_q[7:3])) == 5'b0));

  p_tend_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_i |=> status_q[2] == $past(tx_end_i));

  p_mpb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_i && !rx_done_i) |=> $stable(status_q[1]));

  p_mpbt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_i && !(cs_i && we_i)) |=> $stable(mpb_tx_o));

  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_i && !we_i) |-> rdata_o == 8'h00);
endmodule

bind ser_flag_reg ser_flag_reg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .standby_i (standby_i),
  .cs_i      (cs_i),
  .we_i      (we_i),
  .txe_set_i (txe_set_i),
  .rxf_set_i (rxf_set_i),
  .ovr_set_i (ovr_set_i),
  .frm_set_i (frm_set_i),
  .par_set_i (par_set_i),
  .tx_end_i  (tx_end_i),
  .rx_done_i (rx_done_i),
  .mpb_tx_o  (mpb_tx_o),
  .rdata_o   (rdata_o),
  .status_q  (status_q)
);

// File: tb/ser_flag_reg_test.sv
module ser_flag_reg_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       standby_i, cs_i, we_i;
  logic [7:0] wdata_i, rdata_o;
  logic       txe_set_i, rxf_set_i, ovr_set_i, frm_set_i, par_set_i;
  logic       tx_end_i, rx_done_i, rx_mpb_i, mpb_tx_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model
  logic [7:0] m_reg;
  logic [4:0] m_arm;

  ser_flag_reg uut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .cs_i(cs_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .txe_set_i(txe_set_i),
    .rxf_set_i(rxf_set_i), .ovr_set_i(ovr_set_i), .frm_set_i(frm_set_i),
    .par_set_i(par_set_i), .tx_end_i(tx_end_i), .rx_done_i(rx_done_i),
    .rx_mpb_i(rx_mpb_i), .mpb_tx_o(mpb_tx_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Expected next state, from the requirements
  function automatic logic [12:0] model_next(
      input logic [7:0] r, input logic [4:0] a, input logic s, c, w,
      input logic [7:0] d, input logic [4:0] st, input logic te, rd, rm);
    logic [7:0] nr;
    logic [4:0] na;
    if (s) begin
      nr = 8'h84; na = 5'b0;                                   // R1
    end else begin
      nr = r;
      for (int i = 0; i < 5; i++) begin
        if (st[i])                               nr[3+i] = 1'b1; // R5 R6
        else if (c && w && a[i] && !d[3+i])      nr[3+i] = 1'b0; // R2
        if (c && w)                              na[i] = 1'b0;   // R4
        else if (c && !w && r[3+i])              na[i] = 1'b1;   // R2
        else                                     na[i] = a[i] & r[3+i];
      end
      nr[2] = te;                                                // R7
      if (rd) nr[1] = rm;                                        // R8
      if (c && w) nr[0] = d[0];                                  // R9
    end
    return {na, nr};
  endfunction

  // One cycle: drive at negedge, check before posedge, update model after.
  task automatic cyc(input string tag, input logic s, c, w, input logic [7:0] d,
                     input logic [4:0] st, input logic te, rd, rm);
    logic [12:0] nx;
    standby_i = s; cs_i = c; we_i = w; wdata_i = d;
    {txe_set_i, rxf_set_i, ovr_set_i, frm_set_i, par_set_i} = st;
    tx_end_i = te; rx_done_i = rd; rx_mpb_i = rm;
    #1;
    check({tag, "/R10"}, rdata_o, (c && !w) ? m_reg : 8'h00);
    check({tag, "/R9"}, {7'b0, mpb_tx_o}, {7'b0, m_reg[0]});
    nx = model_next(m_reg, m_arm, s, c, w, d, st, te, rd, rm);
    @(posedge clk);
    {m_arm, m_reg} = nx;
    @(negedge clk);
  endtask

  task automatic rd_(input string tag);  cyc(tag, 0, 1, 0, 8'h00, 5'b0, 1, 0, 0); endtask
  task automatic wr_(input string tag, input logic [7:0] d); cyc(tag, 0, 1, 1, d, 5'b0, 1, 0, 0); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    standby_i = 0; cs_i = 0; we_i = 0; wdata_i = 0;
    {txe_set_i, rxf_set_i, ovr_set_i, frm_set_i, par_set_i} = 5'b0;
    tx_end_i = 1; rx_done_i = 0; rx_mpb_i = 0;
    m_reg = 8'h84; m_arm = 5'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd_("R1 reset value");                         // expect 0x84, arms TXE
    wr_("R2 armed clear", 8'h00);
    rd_("R2 after clear");                         // 0x04
    cyc("R5 rxf set", 0, 0, 0, 8'h00, 5'b01000, 1, 0, 0);
    wr_("R3 unarmed write0", 8'h00);
    rd_("R3 flag kept");                           // arms RXF
    wr_("R4 write ones", 8'hFE);
    wr_("R4 arm consumed", 8'h00);
    rd_("R4 flag kept");                           // arms RXF again
    cyc("R6 set vs clear", 0, 1, 1, 8'h00, 5'b01000, 1, 0, 0);
    rd_("R6 flag kept");
    cyc("R11 standby", 1, 0, 0, 8'h00, 5'b0, 1, 0, 0);
    rd_("R1 after standby");
    cyc("R5 all sets", 0, 0, 0, 8'h00, 5'b11111, 1, 0, 0);
    cyc("R11 standby after set", 1, 0, 0, 8'h00, 5'b0, 1, 0, 0);
    cyc("R5 par set", 0, 0, 0, 8'h00, 5'b00001, 1, 0, 0);
    wr_("R11 write0 unarmed", 8'h00);
    rd_("R11 flag kept");
    cyc("R7 tend low", 0, 1, 1, 8'hFF, 5'b0, 0, 0, 0);
    cyc("R7 tend read", 0, 1, 0, 8'h00, 5'b0, 0, 0, 0);
    cyc("R8 rx done", 0, 0, 0, 8'h00, 5'b0, 1, 1, 1);
    wr_("R8 write ignored", 8'h00);
    rd_("R8 mpb kept");
    wr_("R9 set mpbt", 8'h01);
    rd_("R9 readback");
    wr_("R9 clear mpbt", 8'h00);

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] op;
      logic [4:0] st;
      op = 4'($urandom_range(0, 15));
      st = '0;
      for (int k = 0; k < 5; k++) st[k] = ($urandom_range(0, 9) == 0);
      cyc("R2 R5 random",
          ($urandom_range(0, 63) == 0),
          (op < 4'd12),
          (op < 4'd5),
          8'($urandom),
          st,
          1'($urandom),
          ($urandom_range(0, 3) == 0),
          1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule